// File: doc/BRIEF.md
# Dual-Read Register File with Same-Cycle Write Forwarding

This block is the architectural register store of a pipelined integer core. It holds a set of general-purpose registers, answers two independent register reads on every cycle without waiting for a clock, and accepts one register update per cycle, captured on the rising clock edge.

In a pipeline, the write-back stage often updates a register in the same cycle that the decode stage reads it. The block resolves this case by treating the update as happening early in the cycle and the reads as happening late. Each read port compares its address with the pending write. When the addresses match and the write is enabled, the port returns the incoming write data instead of the older stored value. Register 0 is hard-wired to zero and takes no part in forwarding.

While the active-low reset is held, all updates are dropped and forwarding is disabled. Reset does not clear the stored contents.

Top module: `regfile_fwd`

## Requirements
- R1: The file holds 32 registers of 32 bits, selected by 5-bit register numbers. Ports A and B each read any register independently of the other.
- R2: Reads are combinational. The read data of a port follows its address within the same cycle, with no clock edge in between.
- R3: When the write enable is 1 on a rising clock edge, the write data is stored in the addressed register. A read of that register in any later cycle returns the stored value.
- R4: When the write enable is 0 on a rising edge, no register changes.
- R5: If a port reads the register that an enabled write targets in the same cycle, that port returns the write data. This holds on both ports at once when both read that register.
- R6: Register 0 always reads as 0. Writes to it are discarded, and a same-cycle write to register 0 is never forwarded.
- R7: While rst_ni is 0, writes are dropped and no forwarding takes place. The stored values survive reset.
- R8: A write changes only the addressed register. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; updates on rising edge |
| rst_ni | input | 1 | Active-low reset; blocks writes and forwarding |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Register number to write |
| wdata_i | input | 32 | Data to write |
| raddr_a_i | input | 5 | Register number read on port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 5 | Register number read on port B |
| rdata_b_o | output | 32 | Read data, port B |

## Verification
Writes of distinct values to distinct registers, followed by reads on both ports, show that addressing and capture are correct and that neighbouring registers are left alone.

Same-cycle patterns cover three cases: both ports reading the register being written, one port reading it while the other reads a different register, and the write enable held low. Before each of these, the target register is loaded with a known older value, so a forwarded value can be told apart from a stored one.

Register 0 is both written and forwarded-at, and must still read zero. A write attempted under reset must change neither the output in that cycle nor the register's contents afterwards.

// File: rtl/regfile_fwd_pkg.sv
package regfile_fwd_pkg;
  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned NUM_RD_PORTS = 2;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  // slot 0 is a constant; no flops behind it
  assign regs_o[DATA_W-1:0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_addr_i == ADDR_W'(i))) q <= wr_data_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [DATA_W-1:0] stored;
  logic              fwd_hit;

  assign stored  = regs_i[raddr_i*DATA_W +: DATA_W];
  // forwarding never targets the zero register
  assign fwd_hit = wr_en_i && (wr_addr_i == raddr_i) && (raddr_i != '0);

  always_comb begin
    rdata_o = stored;
    if (fwd_hit) rdata_o = wr_data_i;
  end
endmodule

// File: rtl/regfile_fwd.sv
module regfile_fwd
  import regfile_fwd_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic                       wr_en;
  logic [NUM_REGS*DATA_W-1:0] regs;
  logic [ADDR_W-1:0]          raddr [NUM_RD_PORTS];
  logic [DATA_W-1:0]          rdata [NUM_RD_PORTS];

  assign wr_en    = we_i & rst_ni;
  assign raddr[0] = raddr_a_i;
  assign raddr[1] = raddr_b_i;
  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  rf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (waddr_i),
    .wr_data_i (wdata_i),
    .regs_o    (regs)
  );

  for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port (
      .regs_i    (regs),
      .raddr_i   (raddr[p]),
      .wr_en_i   (wr_en),
      .wr_addr_i (waddr_i),
      .wr_data_i (wdata_i),
      .rdata_o   (rdata[p])
    );
  end
endmodule

// File: rtl/regfile_fwd_checker.sv
module regfile_fwd_checker #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ADDR_W-1:0] raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [ADDR_W-1:0] raddr_b_i,
  input logic [DATA_W-1:0] rdata_b_o
);
  assert_zero_reg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));

  assert_fwd_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == raddr_a_i && waddr_i != '0) |-> (rdata_a_o == wdata_i));

  assert_fwd_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == raddr_b_i && waddr_i != '0) |-> (rdata_b_o == wdata_i));

  assert_write_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i) && $past(waddr_i) != '0 && raddr_b_i == $past(waddr_i)
     && !(we_i && waddr_i == raddr_b_i)) |-> (rdata_b_o == $past(wdata_i)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !we_i && !$past(we_i) && $stable(raddr_a_i)) |-> $stable(rdata_a_o));
endmodule

bind regfile_fwd regfile_fwd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/regfile_fwd_bench.sv
module regfile_fwd_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  ra = '0, rb = '0;
  logic [31:0] da, db;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_fwd u_regfile_fwd (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .rdata_a_o(da), .raddr_b_i(rb), .rdata_b_o(db)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one clocked write; returns at the following falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [4:0] b);
    @(negedge clk); ra = a; rb = b; #1;
  endtask

  task automatic t_reset_state;
    rd(5'd0, 5'd0);
    chk("R6 reset r0 port A", da, 32'h0);
    chk("R6 reset r0 port B", db, 32'h0);
  endtask

  task automatic t_write_read;
    wr(5'd1, 32'h1111_0001);
    wr(5'd2, 32'h2222_0002);
    wr(5'd31, 32'hFFFF_001F);
    rd(5'd1, 5'd2);
    chk("R3 r1 port A", da, 32'h1111_0001);
    chk("R1 r2 port B", db, 32'h2222_0002);
    rd(5'd31, 5'd1);
    chk("R1 r31 port A", da, 32'hFFFF_001F);
    chk("R1 r1 port B", db, 32'h1111_0001);
    ra = 5'd2; #1;  // no clock edge in between
    chk("R2 async addr change", da, 32'h2222_0002);
  endtask

  task automatic t_no_we;
    @(negedge clk); we = 1'b0; waddr = 5'd1; wdata = 32'hDEAD_BEEF; ra = 5'd1; rb = 5'd1;
    #1 chk("R4 no forward when disabled", da, 32'h1111_0001);
    @(negedge clk); #1;
    chk("R4 r1 unchanged", db, 32'h1111_0001);
  endtask

  task automatic t_fwd_both;
    wr(5'd7, 32'h0000_0777);
    @(negedge clk); we = 1'b1; waddr = 5'd7; wdata = 32'hABCD_0007; ra = 5'd7; rb = 5'd7;
    #1;
    chk("R5 forward port A", da, 32'hABCD_0007);
    chk("R5 forward port B", db, 32'hABCD_0007);
    @(negedge clk); we = 1'b1; waddr = 5'd7; wdata = 32'h5555_0007; ra = 5'd2; rb = 5'd7;
    #1;
    chk("R5 other reg on A", da, 32'h2222_0002);
    chk("R5 forward B only", db, 32'h5555_0007);
    @(negedge clk); we = 1'b0; #1;
    chk("R3 forwarded value stored", db, 32'h5555_0007);
  endtask

  task automatic t_zero;
    @(negedge clk); we = 1'b1; waddr = 5'd0; wdata = 32'hCAFE_F00D; ra = 5'd0; rb = 5'd0;
    #1 chk("R6 no forward to r0", da, 32'h0);
    @(negedge clk); we = 1'b0; #1;
    chk("R6 r0 write discarded", db, 32'h0);
  endtask

  task automatic t_reset_block;
    wr(5'd5, 32'hA5A5_0005);
    @(negedge clk); rst_n = 1'b0; we = 1'b1; waddr = 5'd5; wdata = 32'h0BAD_0005; ra = 5'd5; rb = 5'd5;
    #1 chk("R7 no forward in reset", da, 32'hA5A5_0005);
    @(negedge clk); we = 1'b0; rst_n = 1'b1; #1;
    chk("R7 write dropped, value kept", db, 32'hA5A5_0005);
  endtask

  task automatic t_isolation;
    wr(5'd10, 32'h0000_00AA);
    wr(5'd11, 32'h0000_00BB);
    wr(5'd10, 32'h1234_5678);
    rd(5'd10, 5'd11);
    chk("R8 target updated", da, 32'h1234_5678);
    chk("R8 neighbour kept", db, 32'h0000_00BB);
    rd(5'd9, 5'd5);
    chk("R8 r5 kept", db, 32'hA5A5_0005);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_write_read();
    t_no_we();
    t_fwd_both();
    t_zero();
    t_reset_block();
    t_isolation();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule